// File: doc/BRIEF.md
# LPC I/O Cycle Target Engine

This block is the peripheral end of LPC-style I/O read and I/O write cycles. It runs on the bus clock and watches an active-low frame strobe. On every edge it samples a 4-bit multiplexed nibble bus. After a start nibble it decodes the cycle direction and a 16-bit I/O address. It compares that address with a small parameterised table of register addresses. On a hit it answers with a ready sync nibble, then either returns read data or takes in the write data the host has already sent. It then hands the bus back to the host through a drive-high and release sequence.

The register storage is outside the block. The engine presents the index of the matched entry on `reg_sel` and samples `rd_data` for reads. It produces a one-clock commit strobe (`wr_stb` or `rd_stb`) only in the clock where it drives the final 1111 recovery nibble. A cycle that the host cuts short by pulling the frame strobe low again therefore never alters register contents or read side-effect flags. The engine never inserts wait states.

Top module: `lpc_io_target`

## Requirements
- R1: A start is a clock edge where `frm_n` is 0 and `nib_in` is 4'b0000. If `frm_n` stays low for several clocks, the last such edge is the start. The nibble sampled at the next edge (with `frm_n` high) is the direction code: 4'b0000 means read and 4'b0010 means write. Any other code ends the cycle, and the block neither drives the bus nor asserts `busy`.
- R2: The four nibbles after the direction code form the address, most significant nibble first. On a hit against the table `REG_ADDRS` (entry i at bits [16*i+15:16*i]), `busy` is 1 in the clock after the fourth address nibble. On a miss, `busy` stays 0 and `nib_oe` stays 0 for the whole cycle.
- R3: In a write cycle, the two nibbles after the address are the data: bits 3–0 first, then bits 7–4. They are presented unchanged on `wr_data` at commit.
- R4: Counting the start as slot 1, the block drives nothing in the two host turnaround slots (slots 7–8 for a read, 9–10 for a write). It then drives the sync nibble 4'b0000 in slot 9 (read) or slot 11 (write). No other sync value is ever produced.
- R5: In a read, slots 10 and 11 carry `rd_data[3:0]` and then `rd_data[7:4]`. `rd_data` is sampled at the edge that starts the sync slot.
- R6: In both directions, slot 12 carries 4'b1111 with `nib_oe` high, and slot 13 has `nib_oe` low.
- R7: `rd_stb` (read) or `wr_stb` (write) is high for exactly the one clock of slot 12, and `busy` is low in that slot.
- R8: Any edge where `frm_n` is 0 during a cycle aborts it. From the next clock, `nib_oe`, `busy`, `wr_stb` and `rd_stb` are 0, so a register or flag is never committed. If `nib_in` was 4'b0000 at that edge, the edge is also a new start.
- R9: While `rst` is high and in the clock after it is released, `nib_oe`, `busy`, `wr_stb` and `rd_stb` are 0.
- R10: `nib_oe` is high only in the sync, read-data and slot-12 recovery slots of a matched cycle.
- R11: `reg_sel` gives the index of the matching table entry (lowest index if two match). It is valid from the clock after the address and holds through the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_n | input | 1 | Frame strobe from the host, active low |
| nib_in | input | 4 | Nibble sampled from the shared bus |
| nib_out | output | 4 | Nibble driven onto the shared bus |
| nib_oe | output | 1 | Output enable for `nib_out` |
| busy | output | 1 | A matched cycle is in progress |
| reg_sel | output | IDX_W (2) | Index of the matched register entry |
| rd_data | input | 8 | Read data for the entry selected by `reg_sel` |
| wr_stb | output | 1 | Write commit pulse |
| wr_data | output | 8 | Write data, valid with `wr_stb` |
| rd_stb | output | 1 | Read completion pulse for read side effects |

## Verification
The bench aims at the slot alignment of each cycle, the first thing a one-clock error would break. Such an error would move the sync nibble into a turnaround slot or put the commit strobe beside a data nibble instead of the 1111 nibble. It aborts a write during its sync slot and a read during its first data slot, then reads the register back. A design that committed early would return the aborted data or pulse `rd_stb`. Misses, a bad direction code and a start held low over two clocks cover the decode edges. The bench also writes a value whose high nibble is 1111, which separates read data from the recovery nibble.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;
  localparam int ADDR_W = 16;
  localparam int NIB_W  = 4;
  localparam int DATA_W = 8;

  localparam logic [NIB_W-1:0] NIB_START   = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_DIR_RD  = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_DIR_WR  = 4'b0010;
  localparam logic [NIB_W-1:0] NIB_READY   = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_RECOVER = 4'b1111;

  // State names the slot that is on the bus during the current clock.
  typedef enum logic [3:0] {
    S_IDLE, S_DIR, S_ADDR, S_WLO, S_WHI,
    S_HTA1, S_HTA2, S_SYNC, S_RLO, S_RHI
  } seq_st_t;
endpackage

// File: rtl/lpc_addr_match.sv
module lpc_addr_match
  import lpc_io_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = 64'h0060_0064_0CA3_0CA2,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [NUM_REGS-1:0] hits;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_cmp
      assign hits[g] = (addr == REG_ADDRS[g*ADDR_W +: ADDR_W]);
    end
  endgenerate

  assign hit = |hits;

  // Lowest index wins when entries overlap.
  always_comb begin
    idx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/lpc_io_seq.sv
module lpc_io_seq
  import lpc_io_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_n,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [ADDR_W-1:0] addr_full,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_oe,
  output logic              busy,
  output logic [IDX_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb
);
  seq_st_t                  state;
  logic                     is_wr;
  logic [1:0]               acnt;
  logic [ADDR_W-NIB_W-1:0]  addr_sh;
  logic [DATA_W-1:0]        rd_hold;

  assign addr_full = {addr_sh, nib_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      is_wr   <= 1'b0;
      acnt    <= '0;
      addr_sh <= '0;
      rd_hold <= '0;
      wr_data <= '0;
      reg_sel <= '0;
      nib_out <= '0;
      nib_oe  <= 1'b0;
      busy    <= 1'b0;
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (!frm_n) begin
        // Frame low: abort whatever runs, possibly a fresh start.
        state  <= (nib_in == NIB_START) ? S_DIR : S_IDLE;
        nib_oe <= 1'b0;
        busy   <= 1'b0;
      end else begin
        case (state)
          S_IDLE: nib_oe <= 1'b0;
          S_DIR: begin
            acnt <= '0;
            if (nib_in == NIB_DIR_RD) begin
              is_wr <= 1'b0;
              state <= S_ADDR;
            end else if (nib_in == NIB_DIR_WR) begin
              is_wr <= 1'b1;
              state <= S_ADDR;
            end else begin
              state <= S_IDLE;
            end
          end
          S_ADDR: begin
            addr_sh <= addr_full[ADDR_W-NIB_W-1:0];
            acnt    <= acnt + 2'd1;
            if (acnt == 2'd3) begin
              if (hit) begin
                busy    <= 1'b1;
                reg_sel <= hit_idx;
                state   <= is_wr ? S_WLO : S_HTA1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_WLO: begin
            wr_data[3:0] <= nib_in;
            state        <= S_WHI;
          end
          S_WHI: begin
            wr_data[7:4] <= nib_in;
            state        <= S_HTA1;
          end
          S_HTA1: state <= S_HTA2;
          S_HTA2: begin
            rd_hold <= rd_data;
            nib_oe  <= 1'b1;
            nib_out <= NIB_READY;
            state   <= S_SYNC;
          end
          S_SYNC: begin
            if (is_wr) begin
              nib_out <= NIB_RECOVER;
              wr_stb  <= 1'b1;
              busy    <= 1'b0;
              state   <= S_IDLE;
            end else begin
              nib_out <= rd_hold[3:0];
              state   <= S_RLO;
            end
          end
          S_RLO: begin
            nib_out <= rd_hold[7:4];
            state   <= S_RHI;
          end
          S_RHI: begin
            nib_out <= NIB_RECOVER;
            rd_stb  <= 1'b1;
            busy    <= 1'b0;
            state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R4: the first driven nibble of a cycle is always the ready sync code
  p_sync_ready_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_oe) |-> (nib_out == NIB_READY));

  // R10: driving starts only inside a matched cycle
  p_drive_needs_match_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_oe) |-> $past(busy));

  // R2: the match itself never drives the bus
  p_match_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !nib_oe);

  // R7: commit lines up with the recovery nibble and the end of busy
  p_commit_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_stb) |-> (nib_oe && nib_out == NIB_RECOVER && !busy));

  // R7: never both commit pulses at once
  p_one_commit_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_stb}));

  // R6: the bus is released in the clock after the recovery nibble
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_stb) |=> !nib_oe);

  // R8: an abort releases the bus and blocks every commit
  p_abort_r8: assert property (@(posedge clk) disable iff (rst)
    !frm_n |=> (!nib_oe && !busy && !wr_stb && !rd_stb));
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_io_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = 64'h0060_0064_0CA3_0CA2,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_n,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_oe,
  output logic              busy,
  output logic [IDX_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_stb
);
  logic [ADDR_W-1:0] addr_full;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;

  lpc_addr_match #(
    .NUM_REGS  (NUM_REGS),
    .REG_ADDRS (REG_ADDRS)
  ) u_match (
    .addr (addr_full),
    .hit  (hit),
    .idx  (hit_idx)
  );

  lpc_io_seq #(
    .NUM_REGS (NUM_REGS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frm_n     (frm_n),
    .nib_in    (nib_in),
    .addr_full (addr_full),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .nib_out   (nib_out),
    .nib_oe    (nib_oe),
    .busy      (busy),
    .reg_sel   (reg_sel),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb)
  );
endmodule

// File: tb/lpc_io_target_tb.sv
module lpc_io_target_tb;
  localparam int N = 4;
  localparam logic [N*16-1:0] ADDRS = 64'h0060_0064_0CA3_0CA2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_n = 1'b1;
  logic [3:0] nib_in = 4'hF;
  logic [3:0] nib_out;
  logic nib_oe, busy, wr_stb, rd_stb;
  logic [IW-1:0] reg_sel;
  logic [7:0] rd_data, wr_data;

  always #2 clk = ~clk;

  lpc_io_target #(.NUM_REGS(N), .REG_ADDRS(ADDRS)) u_dut (
    .clk(clk), .rst(rst), .frm_n(frm_n), .nib_in(nib_in),
    .nib_out(nib_out), .nib_oe(nib_oe), .busy(busy), .reg_sel(reg_sel),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb)
  );

  // Register storage outside the engine, as the surrounding chip would hold it.
  logic [7:0] regs [N];
  assign rd_data = regs[reg_sel];
  always @(posedge clk) begin
    if (rst) begin
      regs[0] <= 8'hA5; regs[1] <= 8'h3C; regs[2] <= 8'h7E; regs[3] <= 8'h01;
    end else if (wr_stb) begin
      regs[reg_sel] <= wr_data;
    end
  end
  logic [7:0] model [N];

  typedef struct {
    bit oe; logic [3:0] out; bit bsy; bit wr; bit rd;
    logic [7:0] wd; int sel; int tag;
  } exp_t;
  exp_t q[$];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Monitor: one scoreboard item per clock, compared mid-cycle.
  exp_t e;
  bit mis;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      mis = (nib_oe !== e.oe) || (busy !== e.bsy) || (wr_stb !== e.wr) ||
            (rd_stb !== e.rd) || (e.oe && nib_out !== e.out) ||
            (e.wr && (wr_data !== e.wd || int'(reg_sel) != e.sel));
      if (mis) begin
        n_bad++;
        $display("FAIL R%0d: oe/out/busy/wr/rd/wd/sel = %b/%h/%b/%b/%b/%h/%0d expected %b/%h/%b/%b/%b/%h/%0d",
                 e.tag, nib_oe, nib_out, busy, wr_stb, rd_stb, wr_data, reg_sel,
                 e.oe, e.out, e.bsy, e.wr, e.rd, e.wd, e.sel);
      end
    end
  end

  function automatic int find(logic [15:0] a);
    for (int i = 0; i < N; i++) if (ADDRS[i*16 +: 16] == a) return i;
    return -1;
  endfunction

  task automatic push(bit oe, logic [3:0] out, bit bsy, bit wr, bit rd,
                      logic [7:0] wd, int sel, int tag);
    exp_t x;
    x.oe = oe; x.out = out; x.bsy = bsy; x.wr = wr; x.rd = rd;
    x.wd = wd; x.sel = sel; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic drive(bit f, logic [3:0] n);
    @(posedge clk);
    #1;
    frm_n = f;
    nib_in = n;
  endtask

  task automatic idle(int n, int tag);
    repeat (n) begin
      drive(1'b1, 4'hF);
      push(0, 4'h0, 0, 0, 0, 8'h00, 0, tag);
    end
  endtask

  // Driver. kind: 0 read, 1 write, 2 bad direction code (4'h7).
  task automatic io_cycle(int kind, logic [15:0] a, logic [7:0] d,
                          int abort_at, bit long_start);
    int hit = find(a);
    bit ok = (kind < 2) && (hit >= 0);
    bit wr = (kind == 1);
    logic [3:0] h [14];
    logic [7:0] rv;
    rv = (hit >= 0) ? model[hit] : 8'h00;
    for (int k = 0; k < 14; k++) h[k] = 4'hF;
    h[1] = 4'h0;
    h[2] = (kind == 0) ? 4'h0 : (kind == 1) ? 4'h2 : 4'h7;
    h[3] = a[15:12]; h[4] = a[11:8]; h[5] = a[7:4]; h[6] = a[3:0];
    if (wr) begin h[7] = d[3:0]; h[8] = d[7:4]; end
    if (long_start) begin
      drive(1'b0, 4'h0);
      push(0, 4'h0, 0, 0, 0, 8'h00, 0, 1); // R1 held start
    end
    for (int k = 1; k <= 13; k++) begin
      bit eo = 0, eb = 0, ew = 0, er = 0;
      logic [3:0] eout = 4'h0;
      int tag = ok ? 10 : ((kind == 2) ? 1 : 2); // R10 quiet slots, R1/R2 misses
      bit f = (k == 1) ? 1'b0 : 1'b1;
      logic [3:0] n = h[k];
      if (ok) begin
        if (k >= 7 && k <= 11) begin eb = 1; tag = 2; end // R2 busy after match
        if (!wr) begin
          if (k == 9)  begin eo = 1; eout = 4'h0; tag = 4; end       // R4 sync
          if (k == 10) begin eo = 1; eout = rv[3:0]; tag = 5; end    // R5 low
          if (k == 11) begin eo = 1; eout = rv[7:4]; tag = 5; end    // R5 high
          if (k == 12) begin eo = 1; eout = 4'hF; er = 1; tag = 7; end // R7
        end else begin
          if (k == 11) begin eo = 1; eout = 4'h0; tag = 4; end       // R4 sync
          if (k == 12) begin eo = 1; eout = 4'hF; ew = 1; tag = 3; end // R3 R11
        end
        if (k == 13) tag = 6; // R6 release
      end
      if (k == abort_at) begin f = 1'b0; n = 4'h5; end
      drive(f, n);
      push(eo, eout, eb, ew, er, d, hit, tag);
      if (k == abort_at) begin
        idle(2, 8); // R8 abort: bus released, nothing committed
        return;
      end
    end
    if (ok && wr) model[hit] = d;
  endtask

  initial begin
    model[0] = 8'hA5; model[1] = 8'h3C; model[2] = 8'h7E; model[3] = 8'h01;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(3, 9);                             // R9 reset state
    io_cycle(0, 16'h0CA2, 8'h00, 0, 0);     // R5 read entry 0
    io_cycle(1, 16'h0CA3, 8'h5A, 0, 0);     // R3 write entry 1
    idle(1, 10);
    io_cycle(0, 16'h0CA3, 8'h00, 0, 0);     // R5 read back
    io_cycle(1, 16'h0CA4, 8'h99, 0, 0);     // R2 miss on write
    io_cycle(0, 16'h1060, 8'h00, 0, 0);     // R2 miss on read
    io_cycle(2, 16'h0060, 8'h00, 0, 0);     // R1 bad direction code
    io_cycle(1, 16'h0064, 8'hC3, 11, 0);    // R8 abort in write sync slot
    io_cycle(0, 16'h0064, 8'h00, 0, 0);     // R8 old value survives
    io_cycle(0, 16'h0CA2, 8'h00, 10, 0);    // R8 abort during read data
    io_cycle(0, 16'h0060, 8'h00, 0, 1);     // R1 start held two clocks
    io_cycle(1, 16'h0060, 8'hF0, 0, 0);     // R11 entry 3 selected
    io_cycle(0, 16'h0060, 8'h00, 0, 0);     // R5 high nibble 1111 vs recovery R6
    io_cycle(0, 16'h0CA2, 8'h00, 4, 0);     // R8 abort in address
    io_cycle(0, 16'h0CA2, 8'h00, 0, 0);     // R7 full read after abort
    idle(4, 10);
    wait (q.size() == 0);
    @(negedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL all requirements: watchdog expired, actual still running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule